// File: doc/BRIEF.md
# Two-Channel Edge Capture Unit

This block sits beside a free-running 8-bit auto-reload counter and records when external events occur. Each of two channels watches an asynchronous input pin. When the pin shows an edge of the polarity software picked for that channel, the block copies the counter value into that channel's capture register. It also sets the channel's capture flag. If that channel's interrupt is enabled, the interrupt line goes high.

Software reaches the block through a small register bus. It sets polarities and interrupt enables in a shared control/status register and reads the captured timestamps from two read-only registers. Reading the control/status register returns both flags and clears them as a side effect, so each event is reported once. A capture that lands in the same cycle as that read is kept for the next read. The counter, its reload and any waveform outputs belong to other blocks.

Top module: `tmr_capture2`

## Requirements
- R1: After reset the control/status register (offset 0) and both capture registers (offsets 1 and 2) read 00h and `irq` is 0.
- R2: Bits 7:6 of the control/status register always read 0. Writes to bits 1:0 have no effect, and bits 5:2 take the written value.
- R3: Bit 4 selects the polarity for channel 1 and bit 5 for channel 2. A value of 1 captures on a rising edge and 0 on a falling edge. An edge of the other direction causes no capture.
- R4: On a capture, channel 1 stores `cnt_val` in offset 1 and sets flag bit 0. Channel 2 stores it in offset 2 and sets flag bit 1.
- R5: A read of offset 0 returns the flags as they were before the read and clears both flags after it.
- R6: A capture in the same cycle as a read of offset 0 leaves that channel's flag set. The read itself shows the flag's earlier value.
- R7: A new capture overwrites the channel's capture register even while its flag is still set.
- R8: `irq` is 1 exactly when (bit 0 and bit 2) or (bit 1 and bit 3) of the control/status register are both 1. Bit 2 is the channel 1 enable and bit 3 the channel 2 enable.
- R9: Writes to offsets 1, 2 and 3 are ignored, and a read of offset 3 returns 00h.
- R10: `rdata` is 00h whenever `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a read of offset 0 clears the flags |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| cnt_val | input | 8 | Current counter value |
| cap_pin | input | 2 | Asynchronous capture inputs, bit 0 for channel 1 |
| irq | output | 1 | Capture interrupt |

## Verification
The capture path is tried with a rising edge on channel 1, a falling edge on channel 2 and an edge of the wrong direction on each channel. These patterns show whether each polarity bit is tied to the correct channel and direction. Back-to-back captures with different counter values show whether the register overwrites or holds its first value. A read placed in the exact cycle a capture lands shows whether the event survives the clear. Enabling the interrupt only after a flag is already set shows whether `irq` follows the flag-and-enable state rather than the event pulse.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned NUM_CH = 2;
  localparam logic [ADDR_W-1:0] OFS_CSR  = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_CAP1 = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_CAP2 = 2'd2;
  // control/status field positions, decoded by software
  localparam int unsigned POL_LSB = 4;
  localparam int unsigned IEN_LSB = 2;
  localparam int unsigned FLG_LSB = 0;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic evt
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign evt = (sync_q[STAGES-1] != prev_q) && (sync_q[STAGES-1] == pol);
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pin,
  input  logic         pol,
  input  logic         clr,
  input  logic [W-1:0] cnt,
  output logic         evt,
  output logic         flag,
  output logic [W-1:0] data
);
  logic         flag_d;
  logic [W-1:0] data_d;

  cap_edge_det #(.STAGES(STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin(pin), .pol(pol), .evt(evt)
  );

  always_comb begin
    flag_d = flag;
    data_d = data;
    if (clr) flag_d = 1'b0;
    if (evt) begin
      flag_d = 1'b1;
      data_d = cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      data <= '0;
    end else begin
      flag <= flag_d;
      if (evt) data <= data_d;
    end
  end
endmodule

// File: rtl/tmr_capture2.sv
module tmr_capture2
  import cap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic [NUM_CH-1:0] cap_pin,
  output logic              irq
);
  logic [NUM_CH-1:0]             pol_q, pol_d;
  logic [NUM_CH-1:0]             ien_q, ien_d;
  logic [NUM_CH-1:0]             cap_evt;
  logic [NUM_CH-1:0]             flag_q;
  logic [NUM_CH-1:0][DATA_W-1:0] cap_data;
  logic                          csr_wr, csr_rd;

  assign csr_wr = wr_en && (addr == OFS_CSR);
  assign csr_rd = rd_en && (addr == OFS_CSR);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cap_channel #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_ch (
      .clk(clk), .rst_n(rst_n), .pin(cap_pin[c]), .pol(pol_q[c]),
      .clr(csr_rd), .cnt(cnt_val), .evt(cap_evt[c]),
      .flag(flag_q[c]), .data(cap_data[c])
    );
  end

  always_comb begin
    pol_d = pol_q;
    ien_d = ien_q;
    if (csr_wr) begin
      pol_d = wdata[POL_LSB +: NUM_CH];
      ien_d = wdata[IEN_LSB +: NUM_CH];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q <= '0;
      ien_q <= '0;
    end else if (csr_wr) begin
      pol_q <= pol_d;
      ien_q <= ien_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        OFS_CSR: begin
          rdata[POL_LSB +: NUM_CH] = pol_q;
          rdata[IEN_LSB +: NUM_CH] = ien_q;
          rdata[FLG_LSB +: NUM_CH] = flag_q;
        end
        OFS_CAP1: rdata = cap_data[0];
        OFS_CAP2: rdata = cap_data[1];
        default:  rdata = '0;
      endcase
    end
  end

  assign irq = |(flag_q & ien_q);
endmodule

// File: rtl/cap_checker.sv
module cap_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] rdata,
  input logic [7:0] cnt_val,
  input logic [1:0] cap_evt,
  input logic [1:0] flag_q,
  input logic [1:0][7:0] cap_data,
  input logic       irq
);
  // R2
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |-> (rdata[7:6] == 2'b00));

  // R4
  a_r4_ch1_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt[0] |=> (cap_data[0] == $past(cnt_val)) && flag_q[0]);

  // R4
  a_r4_ch2_latch: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt[1] |=> (cap_data[1] == $past(cnt_val)) && flag_q[1]);

  // R5, R6
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0) |=> ((flag_q & ~$past(cap_evt)) == 2'b00));

  // R7
  a_r7_hold_no_evt: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt == 2'b00) |=> $stable(cap_data));

  // R8
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cap_evt) != 2'b00) || $past(wr_en));

  // R10
  a_r10_idle_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> (rdata == 8'h00));
endmodule

bind tmr_capture2 cap_checker u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .rdata(rdata), .cnt_val(cnt_val), .cap_evt(cap_evt), .flag_q(flag_q),
  .cap_data(cap_data), .irq(irq)
);

// File: tb/sim_tmr_capture2.sv
module sim_tmr_capture2;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] addr;
  logic       wr_en, rd_en;
  logic [7:0] wdata, rdata, cnt_val;
  logic [1:0] cap_pin;
  logic       irq;
  int checks = 0;
  int errors = 0;
  logic [7:0] d;

  always #10 clk = ~clk;

  tmr_capture2 u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .cnt_val(cnt_val), .cap_pin(cap_pin),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic drive_pin(input int ch, input logic v);
    @(negedge clk); cap_pin[ch] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    rd(2'd0, d); check("R1 csr", d, 8'h00);
    rd(2'd1, d); check("R1 cap1", d, 8'h00);
    rd(2'd2, d); check("R1 cap2", d, 8'h00);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_bus;
    wr(2'd0, 8'hFF); rd(2'd0, d); check("R2 reserved/flags", d, 8'h3C);
    wr(2'd0, 8'h00); rd(2'd0, d); check("R2 clear ctrl", d, 8'h00);
    wr(2'd1, 8'hA5); rd(2'd1, d); check("R9 cap1 readonly", d, 8'h00);
    wr(2'd2, 8'h5A); rd(2'd2, d); check("R9 cap2 readonly", d, 8'h00);
    wr(2'd3, 8'hFF); rd(2'd3, d); check("R9 offset3", d, 8'h00);
    @(negedge clk); addr = 2'd0; #2 check("R10 idle rdata", rdata, 8'h00);
  endtask

  task automatic t_rise_ch1;
    wr(2'd0, 8'h10); cnt_val = 8'h5A;
    drive_pin(0, 1'b1);
    rd(2'd0, d); check("R3/R4 ch1 rise flag", d, 8'h11);
    rd(2'd1, d); check("R4 ch1 data", d, 8'h5A);
    rd(2'd0, d); check("R5 flag cleared", d, 8'h10);
  endtask

  task automatic t_fall_ch2;
    wr(2'd0, 8'h00); cnt_val = 8'h77;
    drive_pin(1, 1'b1);
    rd(2'd0, d); check("R3 ch2 wrong edge", d, 8'h00);
    rd(2'd2, d); check("R3 ch2 no data", d, 8'h00);
    cnt_val = 8'h3C;
    drive_pin(1, 1'b0);
    rd(2'd0, d); check("R3/R4 ch2 fall flag", d, 8'h02);
    rd(2'd2, d); check("R4 ch2 data", d, 8'h3C);
    rd(2'd1, d); check("R4 ch1 untouched", d, 8'h5A);
    rd(2'd0, d); check("R5 ch2 cleared", d, 8'h00);
  endtask

  task automatic t_overwrite;
    wr(2'd0, 8'h30);
    drive_pin(0, 1'b0);
    rd(2'd0, d); check("R3 ch1 falling ignored", d, 8'h30);
    cnt_val = 8'h11; drive_pin(0, 1'b1);
    cnt_val = 8'h22; drive_pin(0, 1'b0); drive_pin(0, 1'b1);
    rd(2'd1, d); check("R7 overwrite", d, 8'h22);
    rd(2'd0, d); check("R7 flag set", d, 8'h31);
  endtask

  task automatic t_irq;
    wr(2'd0, 8'h34);
    drive_pin(1, 1'b1);
    check("R8 irq disabled ch", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h3C);
    check("R8 irq enabled", {7'd0, irq}, 8'h01);
    rd(2'd0, d); check("R5 read value", d, 8'h3E);
    check("R8 irq after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_collide;
    wr(2'd0, 8'h30);
    drive_pin(0, 1'b0);
    @(negedge clk); cap_pin[0] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); addr = 2'd0; rd_en = 1'b1;
    #2 check("R6 read shows old flag", rdata, 8'h30);
    @(negedge clk); rd_en = 1'b0;
    rd(2'd0, d); check("R6 flag kept", d, 8'h31);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0;
    wdata = '0; cnt_val = '0; cap_pin = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_bus();
    t_rise_ch1();
    t_fall_ch2();
    t_overwrite();
    t_irq();
    t_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule